// File: doc/BRIEF.md
# Calibrated One-Second Timebase Divider

This block turns a 32768 Hz oscillator enable into a one-cycle pulse once per second. It corrects crystal error digitally. It never trims the oscillator. Instead it adds or removes counts at the divide-by-256 stage, on a schedule that repeats every 64 minutes. A 5-bit magnitude N picks how many of the leading minutes in that cycle are corrected: the first 2N minutes. A sign bit picks the direction of the correction. In each corrected minute, only the first second is altered.

A positive correction makes the clock run faster. It removes one whole stage period of 256 oscillator counts from the altered second. A negative correction makes the clock run slower. It holds one stage period for an extra half period, which adds 128 counts. Each step of N therefore moves the 64-minute total by -512 counts (positive) or +256 counts (negative).

A 512 Hz square wave is taken from the uncorrected oscillator count, so the crystal can be measured without the correction affecting it. A stop input freezes every counter. The index of the current minute within the 64-minute cycle is brought out for debug.

Top module: `cal_timebase`

## Requirements
- R1: With a magnitude of 0, every second lasts exactly PRE_DIV*STAGES_PER_SEC oscillator enables (32768 by default). Cycles where osc_en_i is low are not counted.
- R2: With cal_plus_i=1 and magnitude N, the first second of each minute whose index is below 2N is shortened by PRE_DIV enables (256 by default).
- R3: With cal_plus_i=0 and magnitude N, the first second of each minute whose index is below 2N is lengthened by PRE_DIV/2 enables (128 by default).
- R4: All other seconds last the nominal length, including every second of minutes at index 2N or above. Over one 64-minute cycle, the total is the nominal total minus N*2*PRE_DIV (positive) or plus N*PRE_DIV (negative).
- R5: min_idx_o starts at 0 and advances by one after every SECS_PER_MIN ticks. It wraps from MINS_PER_CYCLE-1 (63) to 0. It changes only in the cycle in which tick_o is high.
- R6: The calibration inputs are captured while rst_i is high and again when each minute ends. A change made in the middle of a minute takes effect only from the next minute.
- R7: While stop_i is 1, no counter advances. tick_o stays low, and min_idx_o and test_sq_o hold their values. The second in progress is longer by exactly the number of stopped cycles.
- R8: test_sq_o toggles every TEST_HALF counted enables (32 by default, giving 512 Hz), whatever the calibration inputs are.
- R9: While rst_i is high, tick_o, test_sq_o and min_idx_o are cleared to 0 at the next clock edge.
- R10: tick_o is a registered pulse exactly one clock wide. It is raised in the clock after the enable that completes a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| osc_en_i | input | 1 | One-cycle enable per oscillator period |
| stop_i | input | 1 | Freezes the whole divider while 1 |
| cal_mag_i | input | 5 | Calibration magnitude N, 0..31 |
| cal_plus_i | input | 1 | Correction sign: 1 speeds up, 0 slows down |
| tick_o | output | 1 | One-second pulse |
| test_sq_o | output | 1 | Uncorrected test square wave (512 Hz by default) |
| min_idx_o | output | 6 | Minute index within the 64-minute correction cycle |

## Verification
The bench runs with a scaled-down divider (8 enables per stage, 4 stages per second, 3 seconds per minute). It runs complete 64-minute cycles at four settings: magnitude 0, a small positive magnitude, full negative magnitude and full positive magnitude. These runs tell apart a second that was shortened, one that was lengthened and one that is nominal. They also show where the affected window ends at minute 2N. Summing each cycle separates an off-by-one in that window from a wrong step size.

A mid-minute change of the calibration inputs shows whether they are captured at the minute boundary or used at once. Windows where stop_i is held or osc_en_i is low show whether any state moves while the divider should be frozen. The square-wave period is measured under opposite correction signs to show that the correction does not reach it.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int CAL_W = 5;

  typedef struct packed {
    logic             plus;
    logic [CAL_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/ctb_prescale.sv
// Divide-by-stage counter; one stage period can be stretched by half.
module ctb_prescale #(
  parameter int PRE_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  logic stretch_i,
  output logic stage_end_o
);
  localparam int LONG = PRE_DIV + PRE_DIV / 2;
  localparam int PW   = $clog2(LONG);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last        = stretch_i ? PW'(LONG - 1) : PW'(PRE_DIV - 1);
  assign stage_end_o = step_i && (cnt_q == last);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= stage_end_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctb_stage.sv
// Counts stage periods per second; one stage can be dropped.
module ctb_stage #(
  parameter int STAGES_PER_SEC = 128
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stage_end_i,
  input  logic drop_i,
  output logic first_o,
  output logic sec_end_o
);
  localparam int SW = (STAGES_PER_SEC > 1) ? $clog2(STAGES_PER_SEC) : 1;

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] last;

  assign last      = drop_i ? SW'(STAGES_PER_SEC - 2) : SW'(STAGES_PER_SEC - 1);
  assign first_o   = (cnt_q == '0);
  assign sec_end_o = stage_end_i && (cnt_q == last);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (stage_end_i) begin
      cnt_q <= sec_end_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctb_cycle.sv
// Second/minute position in the correction cycle and calibration capture.
module ctb_cycle
  import ctb_pkg::*;
#(
  parameter int SECS_PER_MIN   = 60,
  parameter int MINS_PER_CYCLE = 64,
  localparam int MIN_W = $clog2(MINS_PER_CYCLE)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sec_end_i,
  input  cal_t             cal_i,
  output logic [MIN_W-1:0] min_idx_o,
  output logic             shorten_o,
  output logic             lengthen_o
);
  localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam int CW = (MIN_W > CAL_W + 1) ? MIN_W : CAL_W + 1;

  logic [SW-1:0]    sec_q;
  logic [MIN_W-1:0] min_q;
  cal_t             cal_q;
  logic             mod_now;

  assign mod_now    = (sec_q == '0) && (CW'(min_q) < CW'({cal_q.mag, 1'b0}));
  assign shorten_o  = mod_now && cal_q.plus;
  assign lengthen_o = mod_now && !cal_q.plus;
  assign min_idx_o  = min_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q <= '0;
      min_q <= '0;
      cal_q <= cal_i;
    end else if (sec_end_i) begin
      if (sec_q == SW'(SECS_PER_MIN - 1)) begin
        sec_q <= '0;
        cal_q <= cal_i;
        min_q <= (min_q == MIN_W'(MINS_PER_CYCLE - 1)) ? '0 : min_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctb_testwave.sv
// Uncorrected square wave taken straight from the oscillator enables.
module ctb_testwave #(
  parameter int TEST_HALF = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  output logic wave_o
);
  logic wave_q;
  assign wave_o = wave_q;

  generate
    if (TEST_HALF <= 1) begin : g_direct
      always_ff @(posedge clk_i) begin
        if (rst_i)       wave_q <= 1'b0;
        else if (step_i) wave_q <= !wave_q;
      end
    end else begin : g_count
      localparam int HW = $clog2(TEST_HALF);
      logic [HW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == HW'(TEST_HALF - 1));
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q  <= '0;
          wave_q <= 1'b0;
        end else if (step_i) begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
          if (wrap) wave_q <= !wave_q;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cal_timebase.sv
module cal_timebase
  import ctb_pkg::*;
#(
  parameter int PRE_DIV        = 256,
  parameter int STAGES_PER_SEC = 128,
  parameter int SECS_PER_MIN   = 60,
  parameter int MINS_PER_CYCLE = 64,
  parameter int TEST_HALF      = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic                              osc_en_i,
  input  logic                              stop_i,
  input  logic [ctb_pkg::CAL_W-1:0]         cal_mag_i,
  input  logic                              cal_plus_i,
  output logic                              tick_o,
  output logic                              test_sq_o,
  output logic [$clog2(MINS_PER_CYCLE)-1:0] min_idx_o
);
  logic step;
  logic stage_end;
  logic sec_end;
  logic first_stage;
  logic shorten;
  logic lengthen;
  logic tick_q;
  cal_t cal_in;

  assign step   = osc_en_i && !stop_i;
  assign cal_in = '{plus: cal_plus_i, mag: cal_mag_i};

  ctb_prescale #(.PRE_DIV(PRE_DIV)) i_prescale (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_i     (step),
    .stretch_i  (lengthen && first_stage),
    .stage_end_o(stage_end)
  );

  ctb_stage #(.STAGES_PER_SEC(STAGES_PER_SEC)) i_stage (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .stage_end_i(stage_end),
    .drop_i     (shorten),
    .first_o    (first_stage),
    .sec_end_o  (sec_end)
  );

  ctb_cycle #(
    .SECS_PER_MIN  (SECS_PER_MIN),
    .MINS_PER_CYCLE(MINS_PER_CYCLE)
  ) i_cycle (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sec_end_i (sec_end),
    .cal_i     (cal_in),
    .min_idx_o (min_idx_o),
    .shorten_o (shorten),
    .lengthen_o(lengthen)
  );

  ctb_testwave #(.TEST_HALF(TEST_HALF)) i_testwave (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .step_i(step),
    .wave_o(test_sq_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= sec_end;
  end
  assign tick_o = tick_q;
endmodule

// File: rtl/cal_timebase_chk.sv
module cal_timebase_chk #(
  parameter int MINS_PER_CYCLE = 64,
  localparam int MIN_W = $clog2(MINS_PER_CYCLE)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             osc_en_i,
  input logic             stop_i,
  input logic             tick_o,
  input logic             test_sq_o,
  input logic [MIN_W-1:0] min_idx_o
);
  p_reset_clear_r9: assert property (@(posedge clk_i)
    rst_i |=> (!tick_o && !test_sq_o && min_idx_o == '0));

  p_tick_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  p_stop_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i |=> (!tick_o && $stable(min_idx_o) && $stable(test_sq_o)));

  p_no_enable_no_tick_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !osc_en_i |=> !tick_o);

  p_min_advance_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(min_idx_o) |-> (tick_o &&
      (($past(min_idx_o) == MIN_W'(MINS_PER_CYCLE - 1)) ? (min_idx_o == '0)
                                                         : (min_idx_o == MIN_W'($past(min_idx_o) + 1'b1)))));

  p_wave_on_step_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(test_sq_o) |-> $past(osc_en_i && !stop_i));
endmodule

bind cal_timebase cal_timebase_chk #(.MINS_PER_CYCLE(MINS_PER_CYCLE)) i_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .osc_en_i (osc_en_i),
  .stop_i   (stop_i),
  .tick_o   (tick_o),
  .test_sq_o(test_sq_o),
  .min_idx_o(min_idx_o)
);

// File: tb/test_cal_timebase.sv
module test_cal_timebase;
  localparam int PRE  = 8;
  localparam int STG  = 4;
  localparam int SECS = 3;
  localparam int MINS = 64;
  localparam int HALF = 4;
  localparam int NOM  = PRE * STG;
  localparam int CYC_TOTAL = NOM * SECS * MINS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b1;
  logic       stop = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic       cal_plus = 1'b0;
  logic       tick;
  logic       test_sq;
  logic [5:0] min_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    q_len[$];
  int    q_min[$];
  string q_req[$];

  int m_min, m_sec, m_mag;
  bit m_plus;

  int  mon_cnt, mon_last, mon_total;
  bit  mon_prev_tick;

  always #10 clk = !clk;

  cal_timebase #(
    .PRE_DIV(PRE), .STAGES_PER_SEC(STG), .SECS_PER_MIN(SECS),
    .MINS_PER_CYCLE(MINS), .TEST_HALF(HALF)
  ) i_cal_timebase (
    .clk_i(clk), .rst_i(rst), .osc_en_i(osc_en), .stop_i(stop),
    .cal_mag_i(cal_mag), .cal_plus_i(cal_plus),
    .tick_o(tick), .test_sq_o(test_sq), .min_idx_o(min_idx)
  );

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures each second and compares against the scoreboard queue.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      mon_cnt = 0; mon_last = 1; mon_total = 0; mon_prev_tick = 1'b0;
    end else begin
      mon_cnt++;
      if (mon_prev_tick) check(!tick, "R10", int'(tick), 0, "tick width");
      if (tick) begin
        int iv;
        iv = mon_cnt - mon_last;
        mon_last = mon_cnt;
        mon_total += iv;
        if (q_len.size() == 0) begin
          check(1'b0, "R1", iv, 0, "unexpected tick");
        end else begin
          int el, em;
          string er;
          el = q_len.pop_front(); em = q_min.pop_front(); er = q_req.pop_front();
          check(iv == el, er, iv, el, "second length");
          check(int'(min_idx) == em, "R5", int'(min_idx), em, "minute index");
        end
      end
      mon_prev_tick = tick;
    end
  end

  // Driver: model of the correction schedule, pushes expected seconds.
  task automatic push_one(int extra, string req);
    int len;
    len = NOM + extra;
    if (m_sec == 0 && m_min < 2 * m_mag) len += m_plus ? -PRE : PRE / 2;
    m_sec++;
    if (m_sec == SECS) begin
      m_sec = 0;
      m_min = (m_min + 1) % MINS;
      m_mag = int'(cal_mag); m_plus = cal_plus;
    end
    q_len.push_back(len); q_min.push_back(m_min); q_req.push_back(req);
  endtask

  task automatic wait_empty();
    while (q_len.size() != 0) @(negedge clk);
  endtask

  task automatic plan(int n, string req);
    for (int i = 0; i < n; i++) push_one(0, req);
    wait_empty();
  endtask

  task automatic do_reset(int mag, bit plus);
    @(negedge clk);
    rst = 1'b1; stop = 1'b0; osc_en = 1'b1;
    cal_mag = 5'(mag); cal_plus = plus;
    q_len.delete(); q_min.delete(); q_req.delete();
    m_min = 0; m_sec = 0; m_mag = mag; m_plus = plus;
    repeat (3) @(negedge clk);
    check(!tick && !test_sq && min_idx == 0, "R9", int'(min_idx), 0, "reset state");
    rst = 1'b0;
  endtask

  task automatic check_wave(int n, string req);
    bit prev;
    @(negedge clk);
    prev = test_sq;
    while (test_sq == prev) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int c;
      c = 0;
      prev = test_sq;
      while (test_sq == prev) begin @(negedge clk); c++; end
      check(c == HALF, req, c, HALF, "test wave half period");
    end
  endtask

  task automatic full_cycle(int mag, bit plus, string req);
    int exp;
    do_reset(mag, plus);
    fork
      plan(SECS * MINS, req);
      check_wave(6, "R8");
    join
    exp = plus ? CYC_TOTAL - mag * 2 * PRE : CYC_TOTAL + mag * PRE;
    check(mon_total == exp, "R4", mon_total, exp, "cycle total");
  endtask

  // Freeze via stop (R7) or via missing enables (R1) for k cycles mid-second.
  task automatic freeze(int k, bit use_stop, string req);
    logic [5:0] m0;
    logic       w0;
    push_one(k, req);
    repeat (5) @(negedge clk);
    m0 = min_idx; w0 = test_sq;
    if (use_stop) stop = 1'b1; else osc_en = 1'b0;
    repeat (k) @(negedge clk);
    check(min_idx == m0 && test_sq == w0, req, int'(test_sq), int'(w0), "state held");
    stop = 1'b0; osc_en = 1'b1;
    wait_empty();
  endtask

  initial begin
    // R1 / R8: nominal seconds, uncorrected wave
    full_cycle(0, 1'b0, "R1");
    // R2 and R5 wrap after a whole cycle
    full_cycle(5, 1'b1, "R2");
    // R3 at full negative span, R8 under negative correction
    full_cycle(31, 1'b0, "R3");
    // R4 boundary: 62 of 64 minutes shortened
    full_cycle(31, 1'b1, "R2");
    // R6: capture at reset and at minute boundaries only
    do_reset(0, 1'b1);
    plan(SECS, "R6");
    cal_mag = 5'd3; cal_plus = 1'b1;
    plan(2 * SECS, "R6");
    plan(1, "R6");
    cal_mag = 5'd31; cal_plus = 1'b0;
    plan(2 * SECS, "R6");
    // R7 stop, R1 enable gaps
    do_reset(2, 1'b0);
    plan(1, "R7");
    freeze(7, 1'b1, "R7");
    freeze(9, 1'b0, "R1");
    plan(SECS, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule